// File: doc/BRIEF.md
# Handshake Packet Transceiver (host side)

This block is the host end of a half-duplex byte link to a small peripheral controller. It does no bit shifting itself. An external 8-bit shift register does that work, and this block tells it which way to shift, hands it each outgoing byte and takes each incoming byte when the register's shift-complete strobe fires. Two active-low handshake lines go from the host to the device: `tip_n` marks a frame in progress and `ack_n` is toggled per byte. An active-low attention line comes back from the device. Outgoing packets are read from an outbound byte buffer that the host fills. Incoming frames are written into an inbound byte buffer that the host reads, and each finished frame is reported by its length and its first byte.

The device may take the link at any moment, even halfway through a send. When it does, the engine drops the send, receives the device's frame and keeps the unsent packet. After a settling hold it sends that packet again from its first byte, or it yields once more if the device is still asking for attention. All waits are counted in microseconds from a prescaled counter, so the same RTL works at any clock rate. After reset a fixed pulse sequence on the handshake lines resets the device before the engine accepts any work.

Top module: `hshk_xcvr`

## Requirements
- R1: Reset drives `tip_n`=1, `ack_n`=1 and `sr_dir_out`=0 (input). The engine then runs its wake-up sequence, with each step taking at least GAP_US microseconds: `tip_n` goes low, then `ack_n` goes low, then `tip_n` goes high, then `ack_n` goes high. `shift_done` has no effect during this sequence.
- R2: At rest, both handshake lines are high and the shift direction is input.
- R3: An accepted send begins at least GAP_US microseconds after the request. In a single cycle the engine sets `sr_dir_out`=1, pulses `sr_load` with buffer byte 0, holds `ack_n` high and drives `tip_n` low.
- R4: While sending, each `shift_done` with `attn_n` high counts one byte out. If bytes remain, the engine loads the next buffer byte and toggles `ack_n`. After the last byte it pulses `tx_done` and returns the lines to rest with direction input.
- R5: At rest, a `shift_done` with `attn_n` low starts a receive. `tip_n` goes low, direction stays input, and the byte carried by that strobe is discarded.
- R6: While receiving, each `shift_done` writes `sr_rx_data` to the next inbound slot, starting at 0. If `attn_n` is low, the engine toggles `ack_n`. If `attn_n` is high, that byte ends the frame: the engine pulses `rx_done`, sets `rx_len` to the number of bytes and `rx_type` to slot 0, and returns the lines to rest.
- R7: A frame that fills all DEPTH slots ends on its last byte even if `attn_n` is still low.
- R8: At rest, a `shift_done` with `attn_n` high is a false start. It leaves `tip_n` high and produces no `rx_done`.
- R9: While sending, a `shift_done` with `attn_n` low aborts the send with no `tx_done`. The engine switches directly to receiving: `tip_n` low, `ack_n` high, direction input, and the packet is kept.
- R10: When a frame ends while a packet is held, the engine waits at least HOLD_US microseconds. Then, if `attn_n` is high, it resends the packet from byte 0. If `attn_n` is low, it starts another receive with `tip_n` low and direction input, and keeps the packet.
- R11: A request is accepted only after wake-up, with `send_len` from 1 to DEPTH and no packet already held. A request made while receiving is held. Every other request produces a one-cycle `req_err` pulse and leaves the engine unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | 1 | Request to send the buffered packet |
| send_len | input | LEN_W | Packet length in bytes |
| req_err | output | 1 | One-cycle pulse: request refused |
| tx_done | output | 1 | One-cycle pulse: packet fully sent |
| ob_wr_en | input | 1 | Outbound buffer write enable |
| ob_wr_addr | input | AW | Outbound buffer write address |
| ob_wr_data | input | 8 | Outbound buffer write data |
| rx_done | output | 1 | One-cycle pulse: frame received |
| rx_len | output | LEN_W | Byte count of the last frame |
| rx_type | output | 8 | First byte of the last frame |
| ib_rd_addr | input | AW | Inbound buffer read address |
| ib_rd_data | output | 8 | Inbound buffer read data (combinational) |
| attn_n | input | 1 | Device attention, active low |
| shift_done | input | 1 | Shift register finished a byte |
| sr_rx_data | input | 8 | Byte held in the shift register |
| sr_dir_out | output | 1 | Shift direction, 1 = output |
| sr_load | output | 1 | Load `sr_load_byte` into the shift register |
| sr_load_byte | output | 8 | Byte to transmit |
| tip_n | output | 1 | Frame-in-progress line, active low |
| ack_n | output | 1 | Byte handshake line, active low |

## Verification
The bound checker watches, on every cycle, the relations between the shift-register controls and the handshake lines. It confirms that loads happen only in output direction with a frame open, that a send opens with `ack_n` high and a load, that both kinds of frame end with the lines at rest, that a collision never yields `tx_done`, and that a refusal always follows a request. Other behaviours involve microsecond spacing, buffer contents, byte order or the order of whole frames: the wake-up pulse order, minimum waits, the dropped dummy byte, the stored frame contents, the forced end at a full buffer, and which way the engine goes when the hold expires. Only the bench scenarios, which act as the device, can show these.

// File: rtl/hshk_pkg.sv
`timescale 1ns/1ps
package hshk_pkg;

    typedef enum logic [2:0] {
        ST_INIT,     // wake-up pulse sequence
        ST_IDLE,
        ST_PRESEND,  // settling wait before a send
        ST_OUT,
        ST_IN,
        ST_HOLD      // settling wait after a frame, packet held
    } hs_state_e;

    typedef struct packed {
        logic tip_n;
        logic ack_n;
        logic dir_out;
    } hs_lines_t;

    localparam hs_lines_t LINES_REST = '{tip_n: 1'b1, ack_n: 1'b1, dir_out: 1'b0};
    localparam logic [1:0] WAKE_LAST = 2'd3;

    function automatic hs_lines_t lines_tx_open();
        return '{tip_n: 1'b0, ack_n: 1'b1, dir_out: 1'b1};
    endfunction

    function automatic hs_lines_t lines_rx_open();
        return '{tip_n: 1'b0, ack_n: 1'b1, dir_out: 1'b0};
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hshk_usdelay.sv
`timescale 1ns/1ps
module hshk_usdelay #(
    parameter int CLKS_PER_US = 200,
    parameter int US_W        = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [US_W-1:0] us,
    output logic            fire
);
    localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CLKS_PER_US - 1);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_left_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q     <= '0;
            us_left_q <= '0;
            run_q     <= 1'b0;
            fire      <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (start) begin
                pre_q     <= PRE_TOP;
                us_left_q <= us;
                run_q     <= (us != '0);
                fire      <= (us == '0);
            end else if (run_q) begin
                if (pre_q == '0) begin
                    pre_q <= PRE_TOP;
                    if (us_left_q == US_W'(1)) begin
                        run_q <= 1'b0;
                        fire  <= 1'b1;
                    end else begin
                        us_left_q <= us_left_q - US_W'(1);
                    end
                end else begin
                    pre_q <= pre_q - PRE_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/hshk_buf.sv
`timescale 1ns/1ps
module hshk_buf #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [7:0]    wd,
    input  logic [AW-1:0] ra,
    output logic [7:0]    rd
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    assign rd = mem[ra];
endmodule

// File: rtl/hshk_xcvr.sv
`timescale 1ns/1ps
module hshk_xcvr
    import hshk_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int CLKS_PER_US = 200,
    parameter int GAP_US      = 150,
    parameter int HOLD_US     = 1500,
    localparam int AW    = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             send_req,
    input  logic [LEN_W-1:0] send_len,
    output logic             req_err,
    output logic             tx_done,
    input  logic             ob_wr_en,
    input  logic [AW-1:0]    ob_wr_addr,
    input  logic [7:0]       ob_wr_data,
    output logic             rx_done,
    output logic [LEN_W-1:0] rx_len,
    output logic [7:0]       rx_type,
    input  logic [AW-1:0]    ib_rd_addr,
    output logic [7:0]       ib_rd_data,
    input  logic             attn_n,
    input  logic             shift_done,
    input  logic [7:0]       sr_rx_data,
    output logic             sr_dir_out,
    output logic             sr_load,
    output logic [7:0]       sr_load_byte,
    output logic             tip_n,
    output logic             ack_n
);
    localparam int US_W = $clog2(max2(GAP_US, HOLD_US) + 1);
    localparam logic [US_W-1:0]  GAP_CNT  = US_W'(GAP_US);
    localparam logic [US_W-1:0]  HOLD_CNT = US_W'(HOLD_US);
    localparam logic [LEN_W-1:0] FULL     = LEN_W'(DEPTH);

    hs_state_e        state_q;
    hs_lines_t        lines_q;
    logic [1:0]       wake_step_q;
    logic [LEN_W-1:0] sent_q, rcv_q, len_q;
    logic             pending_q;
    logic             tmr_go_q;
    logic [US_W-1:0]  tmr_us_q;
    logic             tmr_fire;

    logic [LEN_W-1:0] sent_n, rcv_n;
    logic             accept, pend_eff;
    logic [AW-1:0]    ob_ra;
    logic [7:0]       ob_rd;
    logic             ib_we;

    assign sent_n   = sent_q + LEN_W'(1);
    assign rcv_n    = rcv_q + LEN_W'(1);
    assign accept   = send_req && (state_q != ST_INIT) && !pending_q
                      && (send_len != '0) && (send_len <= FULL);
    assign pend_eff = pending_q || accept;
    assign ob_ra    = (state_q == ST_OUT) ? sent_n[AW-1:0] : '0;
    assign ib_we    = (state_q == ST_IN) && shift_done;

    assign tip_n      = lines_q.tip_n;
    assign ack_n      = lines_q.ack_n;
    assign sr_dir_out = lines_q.dir_out;

    hshk_usdelay #(.CLKS_PER_US(CLKS_PER_US), .US_W(US_W)) u_delay (
        .clk(clk), .rst(rst), .start(tmr_go_q), .us(tmr_us_q), .fire(tmr_fire)
    );

    hshk_buf #(.DEPTH(DEPTH), .AW(AW)) u_obuf (
        .clk(clk), .we(ob_wr_en), .wa(ob_wr_addr), .wd(ob_wr_data),
        .ra(ob_ra), .rd(ob_rd)
    );

    hshk_buf #(.DEPTH(DEPTH), .AW(AW)) u_ibuf (
        .clk(clk), .we(ib_we), .wa(rcv_q[AW-1:0]), .wd(sr_rx_data),
        .ra(ib_rd_addr), .rd(ib_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_INIT;
            lines_q      <= LINES_REST;
            wake_step_q  <= '0;
            sent_q       <= '0;
            rcv_q        <= '0;
            len_q        <= '0;
            pending_q    <= 1'b0;
            tmr_go_q     <= 1'b1;
            tmr_us_q     <= GAP_CNT;
            sr_load      <= 1'b0;
            sr_load_byte <= '0;
            rx_done      <= 1'b0;
            rx_len       <= '0;
            rx_type      <= '0;
            tx_done      <= 1'b0;
            req_err      <= 1'b0;
        end else begin
            tmr_go_q <= 1'b0;
            sr_load  <= 1'b0;
            rx_done  <= 1'b0;
            tx_done  <= 1'b0;
            req_err  <= send_req && !accept;
            if (accept) begin
                pending_q <= 1'b1;
                len_q     <= send_len;
            end
            unique case (state_q)
                ST_INIT: if (tmr_fire) begin
                    wake_step_q <= wake_step_q + 2'd1;
                    unique case (wake_step_q)
                        2'd0:    lines_q.tip_n <= 1'b0;
                        2'd1:    lines_q.ack_n <= ~lines_q.ack_n;
                        2'd2:    lines_q.tip_n <= 1'b1;
                        default: lines_q <= LINES_REST;
                    endcase
                    if (wake_step_q == WAKE_LAST) begin
                        state_q <= ST_IDLE;
                    end else begin
                        tmr_go_q <= 1'b1;
                        tmr_us_q <= GAP_CNT;
                    end
                end
                ST_IDLE: begin
                    if (shift_done && !attn_n) begin
                        lines_q <= lines_rx_open();
                        rcv_q   <= '0;
                        state_q <= ST_IN;
                    end else if (pend_eff) begin
                        state_q  <= ST_PRESEND;
                        tmr_go_q <= 1'b1;
                        tmr_us_q <= GAP_CNT;
                    end
                end
                ST_PRESEND, ST_HOLD: if (tmr_fire) begin
                    if (state_q == ST_HOLD && !attn_n) begin
                        lines_q <= lines_rx_open();
                        rcv_q   <= '0;
                        state_q <= ST_IN;
                    end else begin
                        lines_q      <= lines_tx_open();
                        sr_load      <= 1'b1;
                        sr_load_byte <= ob_rd;
                        sent_q       <= '0;
                        state_q      <= ST_OUT;
                    end
                end
                ST_OUT: if (shift_done) begin
                    if (!attn_n) begin
                        lines_q <= lines_rx_open();
                        sent_q  <= '0;
                        rcv_q   <= '0;
                        state_q <= ST_IN;
                    end else if (sent_n == len_q) begin
                        pending_q <= 1'b0;
                        lines_q   <= LINES_REST;
                        tx_done   <= 1'b1;
                        state_q   <= ST_IDLE;
                    end else begin
                        sent_q        <= sent_n;
                        sr_load       <= 1'b1;
                        sr_load_byte  <= ob_rd;
                        lines_q.ack_n <= ~lines_q.ack_n;
                    end
                end
                ST_IN: if (shift_done) begin
                    if (rcv_q == '0) rx_type <= sr_rx_data;
                    if (attn_n || rcv_n == FULL) begin
                        lines_q <= LINES_REST;
                        rx_done <= 1'b1;
                        rx_len  <= rcv_n;
                        rcv_q   <= '0;
                        if (pend_eff) begin
                            state_q  <= ST_HOLD;
                            tmr_go_q <= 1'b1;
                            tmr_us_q <= HOLD_CNT;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        rcv_q         <= rcv_n;
                        lines_q.ack_n <= ~lines_q.ack_n;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hshk_xcvr_chk.sv
`timescale 1ns/1ps
module hshk_xcvr_chk (
    input logic clk,
    input logic rst,
    input logic send_req,
    input logic req_err,
    input logic tx_done,
    input logic rx_done,
    input logic attn_n,
    input logic shift_done,
    input logic sr_dir_out,
    input logic sr_load,
    input logic tip_n,
    input logic ack_n
);
    // R3 / R4: bytes are only handed over in output direction inside a frame
    assert_load_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
        sr_load |-> (sr_dir_out && !tip_n));

    // R3: a send opens with ack high and byte 0 loaded
    assert_send_open_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(tip_n) && sr_dir_out) |-> (sr_load && ack_n));

    // R4: a finished send leaves the lines at rest
    assert_tx_end_rest_R4: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (tip_n && ack_n && !sr_dir_out));

    // R6: a finished frame leaves the lines at rest
    assert_rx_end_rest_R6: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (tip_n && ack_n && !sr_dir_out));

    // R9: device attention at a byte of a send turns the link round
    assert_preempt_R9: assert property (@(posedge clk) disable iff (rst)
        (shift_done && sr_dir_out && !tip_n && !attn_n)
        |=> (!tx_done && !sr_dir_out && !tip_n && ack_n));

    // R11: a refusal only ever answers a request
    assert_err_cause_R11: assert property (@(posedge clk) disable iff (rst)
        req_err |-> $past(send_req));
endmodule

bind hshk_xcvr hshk_xcvr_chk u_chk (
    .clk(clk), .rst(rst), .send_req(send_req), .req_err(req_err),
    .tx_done(tx_done), .rx_done(rx_done), .attn_n(attn_n),
    .shift_done(shift_done), .sr_dir_out(sr_dir_out), .sr_load(sr_load),
    .tip_n(tip_n), .ack_n(ack_n)
);

// File: tb/hshk_xcvr_tb.sv
`timescale 1ns/1ps
module hshk_xcvr_tb;
    localparam int DEPTH = 16;
    localparam int CPU   = 2;
    localparam int GAP   = 3;
    localparam int HOLD  = 10;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int GAPC  = GAP * CPU;
    localparam int HOLDC = HOLD * CPU;

    // {length, first byte, increment}
    localparam logic [23:0] VEC [6] = '{
        24'h01_5A_00, 24'h02_10_01, 24'h05_A0_13,
        24'h08_FF_FF, 24'h10_00_11, 24'h03_C3_3C
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic send_req = 1'b0;
    logic [LW-1:0] send_len = '0;
    logic req_err, tx_done, rx_done;
    logic ob_wr_en = 1'b0;
    logic [AW-1:0] ob_wr_addr = '0;
    logic [7:0] ob_wr_data = '0;
    logic [LW-1:0] rx_len;
    logic [7:0] rx_type;
    logic [AW-1:0] ib_rd_addr = '0;
    logic [7:0] ib_rd_data;
    logic attn_n = 1'b1;
    logic shift_done = 1'b0;
    logic [7:0] sr_rx_data = '0;
    logic sr_dir_out, sr_load, tip_n, ack_n;
    logic [7:0] sr_load_byte;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hshk_xcvr #(.DEPTH(DEPTH), .CLKS_PER_US(CPU), .GAP_US(GAP), .HOLD_US(HOLD)) u_dut (
        .clk(clk), .rst(rst), .send_req(send_req), .send_len(send_len),
        .req_err(req_err), .tx_done(tx_done), .ob_wr_en(ob_wr_en),
        .ob_wr_addr(ob_wr_addr), .ob_wr_data(ob_wr_data), .rx_done(rx_done),
        .rx_len(rx_len), .rx_type(rx_type), .ib_rd_addr(ib_rd_addr),
        .ib_rd_data(ib_rd_data), .attn_n(attn_n), .shift_done(shift_done),
        .sr_rx_data(sr_rx_data), .sr_dir_out(sr_dir_out), .sr_load(sr_load),
        .sr_load_byte(sr_load_byte), .tip_n(tip_n), .ack_n(ack_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] base, input logic [7:0] step, input int k);
        return 8'(int'(base) + k * int'(step));
    endfunction

    task automatic fill(input int len, input logic [7:0] base, input logic [7:0] step);
        for (int k = 0; k < len; k++) begin
            ob_wr_en = 1'b1; ob_wr_addr = AW'(k); ob_wr_data = pat(base, step, k);
            @(negedge clk);
        end
        ob_wr_en = 1'b0;
    endtask

    task automatic request(input int len, input bit expect_err, input string req);
        send_req = 1'b1; send_len = LW'(len);
        @(negedge clk);
        send_req = 1'b0;
        chk(req_err == expect_err, req, int'(req_err), int'(expect_err));
    endtask

    // Plays the device while the engine sends; waits for the frame to open first.
    task automatic drive_out(input int len, input logic [7:0] base, input logic [7:0] step,
                             input int minw, input string req);
        int  n = 0;
        bit  eack = 1'b1;
        while (tip_n && n < 2000) begin @(negedge clk); n++; end
        chk(n >= minw, {req, " wait before send"}, n, minw);
        chk(sr_dir_out && ack_n && sr_load, "R3 send open lines", {sr_dir_out, ack_n, sr_load}, 7);
        for (int k = 0; k < len; k++) begin
            chk(sr_load_byte == pat(base, step, k), "R4 byte order", sr_load_byte, pat(base, step, k));
            shift_done = 1'b1;
            @(negedge clk);
            shift_done = 1'b0;
            if (k == len - 1) begin
                chk(tx_done && tip_n && ack_n && !sr_dir_out, "R4 send end",
                    {tx_done, tip_n, ack_n, sr_dir_out}, 14);
            end else begin
                eack = !eack;
                chk(ack_n == eack && !tip_n && !tx_done, "R4 ack toggle", ack_n, eack);
            end
        end
    endtask

    // Plays the device while the engine receives.
    task automatic recv_frame(input int n, input logic [7:0] base, input bit started,
                              input bit keep, input string req);
        bit eack = 1'b1;
        if (!started) begin
            attn_n = 1'b0; sr_rx_data = 8'hEE; shift_done = 1'b1;
            @(negedge clk);
            shift_done = 1'b0;
            chk(!tip_n && !sr_dir_out && ack_n && !rx_done, "R5 receive start",
                {tip_n, sr_dir_out, ack_n, rx_done}, 2);
        end
        for (int k = 0; k < n; k++) begin
            sr_rx_data = pat(base, 8'd7, k);
            if (k == n - 1 && !keep) attn_n = 1'b1;
            shift_done = 1'b1;
            @(negedge clk);
            shift_done = 1'b0;
            if (k == n - 1) begin
                chk(rx_done && int'(rx_len) == n && rx_type == base && tip_n && ack_n,
                    req, int'(rx_len), n);
            end else begin
                eack = !eack;
                chk(ack_n == eack && !tip_n && !rx_done, "R6 ack toggle", ack_n, eack);
            end
        end
        attn_n = 1'b1;
        for (int k = 0; k < n; k++) begin
            ib_rd_addr = AW'(k);
            @(negedge clk);
            chk(ib_rd_data == pat(base, 8'd7, k), "R6 stored byte", ib_rd_data, pat(base, 8'd7, k));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t, stage, ta, tb, tc, td, n;
        bit quiet;
        repeat (3) @(negedge clk);
        chk(tip_n && ack_n && !sr_dir_out && !rx_done, "R1 reset state",
            {tip_n, ack_n, sr_dir_out, rx_done}, 12);
        rst = 1'b0;
        request(2, 1'b1, "R11 request during wake-up");

        // R1: wake-up pulse order and spacing; stray strobe ignored
        t = 0; stage = 0; ta = 0; tb = 0; tc = 0; td = 0;
        for (int i = 0; i < 120; i++) begin
            if (t == 8)  begin attn_n = 1'b0; shift_done = 1'b1; end
            if (t == 9)  begin attn_n = 1'b1; shift_done = 1'b0; end
            @(negedge clk); t++;
            if      (stage == 0 && !tip_n) begin ta = t; stage = 1; end
            else if (stage == 1 && !ack_n) begin tb = t; stage = 2; end
            else if (stage == 2 &&  tip_n) begin tc = t; stage = 3; end
            else if (stage == 3 &&  ack_n) begin td = t; stage = 4; end
        end
        chk(stage == 4, "R1 wake-up order", stage, 4);
        chk(ta >= GAPC && tb - ta >= GAPC, "R1 wake-up spacing a", tb - ta, GAPC);
        chk(tc - tb >= GAPC && td - tc >= GAPC, "R1 wake-up spacing b", td - tc, GAPC);
        chk(tip_n && ack_n && !sr_dir_out && !rx_done, "R2 rest after wake-up (R1 strobe ignored)",
            {tip_n, ack_n, sr_dir_out}, 6);

        // R3 / R4: vector table of outgoing packets
        foreach (VEC[v]) begin
            fill(int'(VEC[v][23:16]), VEC[v][15:8], VEC[v][7:0]);
            request(int'(VEC[v][23:16]), 1'b0, "R11 accept in rest");
            drive_out(int'(VEC[v][23:16]), VEC[v][15:8], VEC[v][7:0], GAPC, "R3");
            @(negedge clk);
            chk(tip_n && ack_n && !sr_dir_out, "R2 rest after send", {tip_n, ack_n, sr_dir_out}, 6);
        end

        // R8: false start
        attn_n = 1'b1; shift_done = 1'b1;
        @(negedge clk);
        shift_done = 1'b0;
        quiet = 1'b1;
        repeat (6) begin
            if (!tip_n || rx_done) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet, "R8 false start ignored", quiet, 1);

        // R5 / R6: ordinary frame
        recv_frame(3, 8'hB1, 1'b0, 1'b0, "R6 frame end");
        // R7: full buffer ends the frame with attention still low
        recv_frame(DEPTH, 8'h20, 1'b0, 1'b1, "R7 forced end");

        // R9 then R10 retry
        fill(3, 8'h70, 8'h01);
        request(3, 1'b0, "R11 accept");
        n = 0;
        while (tip_n && n < 2000) begin @(negedge clk); n++; end
        shift_done = 1'b1;
        @(negedge clk);
        attn_n = 1'b0;
        @(negedge clk);
        shift_done = 1'b0;
        chk(!tip_n && ack_n && !sr_dir_out && !tx_done, "R9 pre-empted send",
            {tip_n, ack_n, sr_dir_out, tx_done}, 4);
        recv_frame(2, 8'h90, 1'b1, 1'b0, "R9 frame after pre-empt");
        drive_out(3, 8'h70, 8'h01, HOLDC / 2, "R10 retry");

        // R10: request held during a receive, attention low when hold expires
        fill(2, 8'h44, 8'h02);
        attn_n = 1'b0; shift_done = 1'b1; sr_rx_data = 8'hEE;
        @(negedge clk);
        shift_done = 1'b0;
        request(2, 1'b0, "R11 request held during receive");
        recv_frame(1, 8'h55, 1'b1, 1'b0, "R6 frame end");
        attn_n = 1'b0;
        n = 0;
        while (tip_n && n < 2000) begin @(negedge clk); n++; end
        chk(n >= HOLDC / 2 && !sr_dir_out, "R10 yield at hold end", n, HOLDC);
        recv_frame(2, 8'h66, 1'b1, 1'b0, "R10 second frame");
        drive_out(2, 8'h44, 8'h02, HOLDC / 2, "R10 retry");

        // R11: refused requests have no effect
        @(negedge clk);
        request(0, 1'b1, "R11 zero length");
        request(DEPTH + 1, 1'b1, "R11 over length");
        quiet = 1'b1;
        repeat (3 * GAPC) begin
            if (!tip_n) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet, "R11 refused request idle", quiet, 1);
        fill(2, 8'h31, 8'h01);
        request(2, 1'b0, "R11 accept");
        request(5, 1'b1, "R11 second request while held");
        drive_out(2, 8'h31, 8'h01, GAPC - 2, "R11 held packet");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule